// File: doc/BRIEF.md
# Cartridge Bank-Select Latch

This block is the bank controller on the cartridge side of a game console. It holds one 8-bit register that the CPU can only write. The CPU loads it by writing to any address in the program-ROM window. The register bits then drive three things:

- the program-ROM bank address lines, where the 16 KiB window at CPU A14 = 0 is switchable and the window at CPU A14 = 1 is fixed to the last bank;
- four character-memory bank address lines;
- a one-screen nametable select.

Combinational logic also forms the character-memory chip select and the nametable A10 line. The nametable line depends on a static mirroring strap. A second strap picks between character RAM and character ROM. The memories are external and are modelled only in the bench.

The register is loaded when the CPU read/write line rises while the ROM-window select is held low. The rising edge is detected inside the system clock domain by a two-state write-capture machine:

- `WR_WATCH`: the machine waits here for a write inside the window. When read/write and the ROM-window select are both low, it stores the data bus and moves to `WR_ARMED` (transition *arm*).
- `WR_ARMED`: while the write stays low it keeps storing the bus (transition *hold*). When read/write rises with the window still selected, it loads the register and returns to `WR_WATCH` (transition *commit*). If the window select goes high first, it returns to `WR_WATCH` without loading (transition *abandon*).

The ROM drives the same data bus during the write, so the value that lands in the register is the AND of the CPU byte and the ROM byte.

Top module: `bank_latch_ctrl`

## Requirements
- R1: After reset the register is zero. With CPU A14 = 0, `prg_bank_a` is 0 and `chr_bank_a` is 0.
- R2: The register loads the data bus value that was present in the last cycle `cpu_rw` was low. The load happens in the cycle in which `cpu_rw` is first seen high while `cpu_romsel_n` is still low. With a conflicting ROM, the loaded value is the AND of the CPU byte and the ROM byte.
- R3: A `cpu_rw` pulse while `cpu_romsel_n` is high leaves the register unchanged.
- R4: With CPU A14 = 1, `prg_bank_a` is 3'b111.
- R5: With CPU A14 = 0, `prg_bank_a[0]`, `prg_bank_a[1]` and `prg_bank_a[2]` (program A14, A15, A16) equal register bits 4, 5 and 6.
- R6: `chr_bank_a[0]`, `chr_bank_a[1]`, `chr_bank_a[2]` and `chr_bank_a[3]` (character A13, A14, A15, A16) equal register bits 0, 1, 2 and 7.
- R7: With `cfg_chr_ram` = 0, `chr_cs_n` is the OR of `ppu_rd_n` and `ppu_a13`.
- R8: With `cfg_chr_ram` = 1, the read strobe is ignored and `chr_cs_n` equals `ppu_a13`.
- R9: `cfg_mirror` = 2'b00 gives `vram_a10` = `ppu_a11`. `cfg_mirror` = 2'b01 gives `vram_a10` = `ppu_a10`.
- R10: `cfg_mirror` = 2'b10 or 2'b11 gives `vram_a10` = register bit 3, whatever the PPU address.
- R11: If `cpu_romsel_n` goes high while `cpu_rw` is still low, and `cpu_rw` rises after that, the register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the CPU bus |
| rst_n | input | 1 | Active-low reset; clears the register |
| cpu_d | input | 8 | CPU data bus, with the ROM byte already merged in |
| cpu_romsel_n | input | 1 | Active-low program-ROM window select |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_rw | input | 1 | CPU read/write (1 = read) |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| ppu_a13 | input | 1 | PPU address bit 13 |
| ppu_rd_n | input | 1 | PPU active-low read strobe |
| cfg_mirror | input | 2 | Mirroring strap: 00 horizontal, 01 vertical, 1x one-screen |
| cfg_chr_ram | input | 1 | Strap: 1 = character RAM fitted, 0 = character ROM |
| prg_bank_a | output | 3 | Program ROM A16..A14 (index 0 = A14) |
| chr_bank_a | output | 4 | Character memory A16..A13 (index 0 = A13) |
| chr_cs_n | output | 1 | Active-low character memory chip select |
| vram_a10 | output | 1 | Nametable RAM A10 |

## Verification
The assertions rely on the CPU and PPU inputs being synchronous to `clk` and steady across each sampling edge. They also rely on `cpu_romsel_n` staying low through the cycle in which `cpu_rw` rises, and on the straps changing only while no write is in flight. The bench changes every input on the falling clock edge only. Each write is a sequence of one low `cpu_rw` cycle, a rising cycle with the window still selected, and then a window release. Straps are changed only between write sequences. Bus conflicts are produced by the bench itself: it drives the AND of the intended byte and its own ROM model's byte onto `cpu_d`.

// File: rtl/blsw_pkg.sv
package blsw_pkg;

    typedef enum logic [0:0] {
        WR_WATCH = 1'b0,
        WR_ARMED = 1'b1
    } wr_state_e;

    typedef enum logic [1:0] {
        MIR_HORZ  = 2'b00,
        MIR_VERT  = 2'b01,
        MIR_ONE_A = 2'b10,
        MIR_ONE_B = 2'b11
    } mirror_e;

    // Register bit that selects the one-screen nametable page
    localparam int NT_BIT  = 3;
    // Lowest register bit of the program bank field
    localparam int PRG_LSB = 4;

    // Register bit that feeds character address line i (i = 0 is A13)
    function automatic int chr_src_bit(input int i);
        return (i < 3) ? i : 7;
    endfunction

endpackage

// File: rtl/blsw_write_fsm.sv
module blsw_write_fsm
    import blsw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              romsel_n,
    input  logic              rw,
    input  logic [DATA_W-1:0] din,
    output logic              load,
    output logic [DATA_W-1:0] load_data
);

    wr_state_e         state_q, state_d;
    logic [DATA_W-1:0] hold_q;
    logic              hold_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WR_WATCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Data sampled while the write strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (hold_en) begin
            hold_q <= din;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        hold_en = 1'b0;
        unique case (state_q)
            WR_WATCH: begin
                if (!romsel_n && !rw) begin
                    // arm
                    hold_en = 1'b1;
                    state_d = WR_ARMED;
                end
            end
            WR_ARMED: begin
                if (romsel_n) begin
                    // abandon
                    state_d = WR_WATCH;
                end else if (rw) begin
                    // commit
                    load    = 1'b1;
                    state_d = WR_WATCH;
                end else begin
                    // hold
                    hold_en = 1'b1;
                end
            end
            default: state_d = WR_WATCH;
        endcase
    end

    assign load_data = hold_q;

endmodule

// File: rtl/blsw_bank_reg.sv
module blsw_bank_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] bank_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load) begin
            bank_q <= load_data;
        end
    end

endmodule

// File: rtl/blsw_addr_map.sv
module blsw_addr_map
    import blsw_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PRG_LINES = 3,
    parameter int CHR_LINES = 4
) (
    input  logic [DATA_W-1:0]    bank_q,
    input  logic                 cpu_a14,
    input  logic                 ppu_a13,
    input  logic                 ppu_rd_n,
    input  logic                 cfg_chr_ram,
    output logic [PRG_LINES-1:0] prg_bank_a,
    output logic [CHR_LINES-1:0] chr_bank_a,
    output logic                 chr_cs_n
);

    // The upper window is forced to the last bank by OR gates
    for (genvar i = 0; i < PRG_LINES; i++) begin : g_prg
        assign prg_bank_a[i] = cpu_a14 | bank_q[PRG_LSB + i];
    end

    for (genvar i = 0; i < CHR_LINES; i++) begin : g_chr
        localparam int SRC = chr_src_bit(i);
        assign chr_bank_a[i] = bank_q[SRC];
    end

    // With RAM fitted, the read strobe input of the OR gate is grounded
    logic rd_term;
    assign rd_term  = ppu_rd_n & ~cfg_chr_ram;
    assign chr_cs_n = rd_term | ppu_a13;

endmodule

// File: rtl/blsw_nt_select.sv
module blsw_nt_select
    import blsw_pkg::*;
(
    input  logic [1:0] cfg_mirror,
    input  logic       ppu_a10,
    input  logic       ppu_a11,
    input  logic       one_screen_page,
    output logic       vram_a10
);

    mirror_e mode;
    assign mode = mirror_e'(cfg_mirror);

    always_comb begin
        unique case (mode)
            MIR_HORZ:  vram_a10 = ppu_a11;
            MIR_VERT:  vram_a10 = ppu_a10;
            MIR_ONE_A,
            MIR_ONE_B: vram_a10 = one_screen_page;
            default:   vram_a10 = ppu_a10;
        endcase
    end

endmodule

// File: rtl/bank_latch_ctrl.sv
module bank_latch_ctrl
    import blsw_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PRG_LINES = 3,
    parameter int CHR_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    cpu_d,
    input  logic                 cpu_romsel_n,
    input  logic                 cpu_a14,
    input  logic                 cpu_rw,
    input  logic                 ppu_a10,
    input  logic                 ppu_a11,
    input  logic                 ppu_a13,
    input  logic                 ppu_rd_n,
    input  logic [1:0]           cfg_mirror,
    input  logic                 cfg_chr_ram,
    output logic [PRG_LINES-1:0] prg_bank_a,
    output logic [CHR_LINES-1:0] chr_bank_a,
    output logic                 chr_cs_n,
    output logic                 vram_a10
);

    logic              load;
    logic [DATA_W-1:0] load_data;
    logic [DATA_W-1:0] bank_q;

    blsw_write_fsm #(.DATA_W(DATA_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .romsel_n  (cpu_romsel_n),
        .rw        (cpu_rw),
        .din       (cpu_d),
        .load      (load),
        .load_data (load_data)
    );

    blsw_bank_reg #(.DATA_W(DATA_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .bank_q    (bank_q)
    );

    blsw_addr_map #(
        .DATA_W    (DATA_W),
        .PRG_LINES (PRG_LINES),
        .CHR_LINES (CHR_LINES)
    ) u_map (
        .bank_q      (bank_q),
        .cpu_a14     (cpu_a14),
        .ppu_a13     (ppu_a13),
        .ppu_rd_n    (ppu_rd_n),
        .cfg_chr_ram (cfg_chr_ram),
        .prg_bank_a  (prg_bank_a),
        .chr_bank_a  (chr_bank_a),
        .chr_cs_n    (chr_cs_n)
    );

    blsw_nt_select u_nt (
        .cfg_mirror      (cfg_mirror),
        .ppu_a10         (ppu_a10),
        .ppu_a11         (ppu_a11),
        .one_screen_page (bank_q[NT_BIT]),
        .vram_a10        (vram_a10)
    );

endmodule

// File: rtl/bank_latch_ctrl_chk.sv
module bank_latch_ctrl_chk #(
    parameter int DATA_W    = 8,
    parameter int PRG_LINES = 3,
    parameter int CHR_LINES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cpu_romsel_n,
    input logic                 cpu_a14,
    input logic                 cpu_rw,
    input logic                 ppu_a13,
    input logic                 ppu_rd_n,
    input logic [1:0]           cfg_mirror,
    input logic                 cfg_chr_ram,
    input logic [DATA_W-1:0]    bank_q,
    input logic [PRG_LINES-1:0] prg_bank_a,
    input logic [CHR_LINES-1:0] chr_bank_a,
    input logic                 chr_cs_n,
    input logic                 vram_a10
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (chr_bank_a == '0));

    // R2
    rw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_q) |-> ($past(cpu_rw) && !$past(cpu_romsel_n)));

    // R3
    outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_romsel_n |=> $stable(bank_q));

    // R4
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_a14 |-> (prg_bank_a == '1));

    // R7
    cs_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_chr_ram && !ppu_rd_n && !ppu_a13) |-> !chr_cs_n);

    // R8
    cs_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chr_ram |-> (chr_cs_n == ppu_a13));

    // R10
    one_screen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mirror[1] |-> (vram_a10 == bank_q[3]));

endmodule

bind bank_latch_ctrl bank_latch_ctrl_chk #(
    .DATA_W    (DATA_W),
    .PRG_LINES (PRG_LINES),
    .CHR_LINES (CHR_LINES)
) u_chk (.*);

// File: tb/bank_latch_ctrl_test.sv
module bank_latch_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cpu_d;
    logic       cpu_romsel_n, cpu_a14, cpu_rw;
    logic       ppu_a10, ppu_a11, ppu_a13, ppu_rd_n;
    logic [1:0] cfg_mirror;
    logic       cfg_chr_ram;
    logic [2:0] prg_bank_a;
    logic [3:0] chr_bank_a;
    logic       chr_cs_n, vram_a10;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    bank_latch_ctrl uut (.*);

    // {value written, expected prg lines at A14=0, expected chr lines}
    localparam logic [14:0] VEC [6] = '{
        {8'h00, 3'b000, 4'b0000},
        {8'h71, 3'b111, 4'b0001},
        {8'h8E, 3'b000, 4'b1110},
        {8'h25, 3'b010, 4'b0101},
        {8'hD3, 3'b101, 4'b1011},
        {8'h4A, 3'b100, 4'b0010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ROM byte seen by the bench at (bank, offset)
    function automatic logic [7:0] rom_byte(input logic [2:0] bank, input logic [7:0] off);
        return (off == 8'h00) ? 8'hFF : (off ^ {5'b0, bank});
    endfunction

    // One CPU write: low strobe, rise inside window, release window
    task automatic cpu_write(input logic [7:0] val, input logic a14, input logic [7:0] off,
                             input logic [2:0] cur_bank);
        logic [2:0] bank_seen;
        bank_seen = a14 ? 3'b111 : cur_bank;
        @(negedge clk);
        cpu_a14 = a14; cpu_romsel_n = 1'b0; cpu_rw = 1'b0;
        cpu_d = val & rom_byte(bank_seen, off);
        @(negedge clk);
        cpu_rw = 1'b1;
        @(negedge clk);
        cpu_romsel_n = 1'b1; cpu_a14 = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_d = 8'h00; cpu_romsel_n = 1'b1; cpu_a14 = 1'b0; cpu_rw = 1'b1;
        ppu_a10 = 1'b0; ppu_a11 = 1'b0; ppu_a13 = 1'b0; ppu_rd_n = 1'b1;
        cfg_mirror = 2'b00; cfg_chr_ram = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 prg", prg_bank_a, 3'b000);
        check("R1 chr", chr_bank_a, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 load, R5 prg field, R6 chr field, R4 fixed upper bank
        for (int i = 0; i < 6; i++) begin
            cpu_write(VEC[i][14:7], 1'b0, 8'h00, prg_bank_a);
            check("R5 prg", prg_bank_a, VEC[i][6:4]);
            check("R6 chr", chr_bank_a, VEC[i][3:0]);
            cpu_a14 = 1'b1; #0.5;
            check("R4 upper", prg_bank_a, 3'b111);
            cpu_a14 = 1'b0; @(negedge clk);
        end

        // R2 bus conflict: 0xF7 & rom(7,0x3C)=0x3B -> 0x33
        cpu_write(8'hF7, 1'b1, 8'h3C, 3'b111);
        check("R2 conflict prg", prg_bank_a, 3'b011);
        check("R2 conflict chr", chr_bank_a, 4'b0011);

        // R3 strobe outside window
        @(negedge clk); cpu_d = 8'hFF; cpu_rw = 1'b0;
        @(negedge clk); cpu_rw = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R3 prg", prg_bank_a, 3'b011);
        check("R3 chr", chr_bank_a, 4'b0011);

        // R11 window released before strobe rises
        @(negedge clk); cpu_d = 8'hFF; cpu_romsel_n = 1'b0; cpu_rw = 1'b0;
        @(negedge clk); cpu_romsel_n = 1'b1;
        @(negedge clk); cpu_rw = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R11 prg", prg_bank_a, 3'b011);
        check("R11 chr", chr_bank_a, 4'b0011);

        // R7 chip select, ROM configuration
        cfg_chr_ram = 1'b0;
        for (int k = 0; k < 4; k++) begin
            ppu_rd_n = k[0]; ppu_a13 = k[1]; #0.5;
            check("R7 cs", chr_cs_n, k[0] | k[1]);
        end
        // R8 chip select, RAM configuration
        cfg_chr_ram = 1'b1;
        for (int k = 0; k < 4; k++) begin
            ppu_rd_n = k[0]; ppu_a13 = k[1]; #0.5;
            check("R8 cs", chr_cs_n, k[1]);
        end
        cfg_chr_ram = 1'b0; ppu_rd_n = 1'b1; ppu_a13 = 1'b0;
        @(negedge clk);

        // R9 horizontal and vertical
        cfg_mirror = 2'b00; ppu_a11 = 1'b1; ppu_a10 = 1'b0; #0.5;
        check("R9 horz", vram_a10, 1'b1);
        ppu_a11 = 1'b0; ppu_a10 = 1'b1; #0.5;
        check("R9 horz", vram_a10, 1'b0);
        cfg_mirror = 2'b01; #0.5;
        check("R9 vert", vram_a10, 1'b1);
        ppu_a10 = 1'b0; ppu_a11 = 1'b1; #0.5;
        check("R9 vert", vram_a10, 1'b0);
        @(negedge clk);

        // R10 one-screen from bit 3
        cfg_mirror = 2'b10;
        cpu_write(8'h08, 1'b0, 8'h00, prg_bank_a);
        ppu_a10 = 1'b0; ppu_a11 = 1'b0; #0.5;
        check("R10 page1", vram_a10, 1'b1);
        cfg_mirror = 2'b11; ppu_a10 = 1'b1; ppu_a11 = 1'b1; #0.5;
        check("R10 page1 alt", vram_a10, 1'b1);
        cpu_write(8'h00, 1'b0, 8'h00, prg_bank_a);
        check("R10 page0", vram_a10, 1'b0);

        // R1 reset mid-run clears a loaded value
        cpu_write(8'hFF, 1'b0, 8'h00, prg_bank_a);
        rst_n = 1'b0; @(negedge clk);
        check("R1 re-reset chr", chr_bank_a, 4'b0000);
        check("R1 re-reset prg", prg_bank_a, 3'b000);
        rst_n = 1'b1; @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule